// File: doc/BRIEF.md
# Dual-Clock Mailbox Bypass Pair

This block moves single 36-bit words between two ports that run on unrelated clocks, in both directions, without passing through the main queue. Each direction owns one holding register and one "mail waiting" flag. A port writes the register with a mailbox-steered write access. The flag then tells the other port that a word is waiting. When that port reads with the mailbox select raised, it takes the held word. Its read clears the flag, and the sender may then post again.

Port A is always 36 bits wide. Port B has a configurable bus size, and only the lanes that fit that size carry mail in either direction. Each flag crosses between the domains through a two-flop synchronizer, so each side has its own copy of the flag, timed to its own clock.

Top module: `mailbox_pair`

## Requirements
- R1: While `rst_n` is low, and after it rises until the first mailbox write, all four flag outputs read 0 and both read-data outputs read 0.
- R2: A write access is `*_cs_n`=0, `*_wr`=1, `*_en`=1 and `*_mbx`=1 at a rising edge of the port's own clock. When the sender's outgoing flag is 0, it stores the word, and the outgoing flag (`a_out_full`/`b_out_full`) reads 1 right after that edge.
- R3: The receiver's incoming flag (`b_in_full`/`a_in_full`) is still 0 after the first rising edge of the receiving clock that follows the write edge, and reads 1 after the second.
- R4: A read access is `*_cs_n`=0, `*_wr`=0, `*_en`=1 and `*_mbx`=1 at a receiving clock edge. After that edge, `*_mail_rdata` shows the held word. The word stays in the register, so a repeated read returns it again.
- R5: A read access while the incoming flag is 1 drops that flag right after the read edge. The sender's outgoing flag is still 1 after the first sending-clock edge that follows, and reads 0 after the second.
- R6: A write access while the outgoing flag is 1 is ignored: the held word is unchanged.
- R7: An access with `*_mbx`=0, `*_en`=0 or `*_cs_n`=1 neither stores a word nor sets any flag.
- R8: `b_bus_size` sets how many lanes port B uses: 2'b00 = 36 bits, 2'b01 = 18 bits (lanes 0..17), 2'b10 = 9 bits (lanes 0..8), 2'b11 = 36 bits. A word that port B reads shows zero above its lanes. A word that port B writes is stored with zeros above its lanes, and port A reads those zeros.
- R9: `*_mail_rdata` changes only on a read access at its port.
- R10: The two directions are independent. Mail moving from B to A leaves the A-to-B flags at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| clk_b | input | 1 | Port B clock, unrelated to clk_a |
| rst_n | input | 1 | Active-low asynchronous master reset for both domains |
| b_bus_size | input | 2 | Port B bus size code (R8), held static while in use |
| a_cs_n | input | 1 | Port A select, active low |
| a_wr | input | 1 | Port A direction: 1 = write, 0 = read |
| a_en | input | 1 | Port A access enable |
| a_mbx | input | 1 | Port A steers the access to the mailbox |
| a_wdata | input | 36 | Word posted from A to B |
| a_mail_rdata | output | 36 | Word received from B, registered on clk_a |
| a_out_full | output | 1 | A-to-B word still unread (clk_a domain) |
| a_in_full | output | 1 | B-to-A word waiting (clk_a domain) |
| b_cs_n | input | 1 | Port B select, active low |
| b_wr | input | 1 | Port B direction: 1 = write, 0 = read |
| b_en | input | 1 | Port B access enable |
| b_mbx | input | 1 | Port B steers the access to the mailbox |
| b_wdata | input | 36 | Word posted from B to A |
| b_mail_rdata | output | 36 | Word received from A, registered on clk_b |
| b_out_full | output | 1 | B-to-A word still unread (clk_b domain) |
| b_in_full | output | 1 | A-to-B word waiting (clk_b domain) |

## Verification
Each flag is the XOR of a local toggle and a synchronized remote toggle. A toggle that flips wrongly, or a synchronizer stage too many or too few, shows as a flag edge one clock early or late. It can also leave a flag stuck at 1, which blocks every later post. The bench therefore samples each flag on every edge around a write and around a read. A lost block on a full register shows only when the receiver reads a word that was overwritten. A wrong lane mask shows on the first read at a narrow bus size.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    parameter int MBX_W  = 36;
    parameter int LANE_W = MBX_W / 4;
    parameter int HALF_W = MBX_W / 2;

    typedef logic [MBX_W-1:0] word_t;

    typedef enum logic [1:0] {
        SZ_FULL    = 2'b00,
        SZ_HALF    = 2'b01,
        SZ_QUARTER = 2'b10,
        SZ_WIDE    = 2'b11
    } bus_size_e;

    function automatic word_t lane_mask(input logic [1:0] size);
        word_t m;
        case (size)
            SZ_HALF:    m = word_t'({HALF_W{1'b1}});
            SZ_QUARTER: m = word_t'({LANE_W{1'b1}});
            default:    m = '1;
        endcase
        return m;
    endfunction

    function automatic logic is_access(input logic cs_n, input logic wr_sel,
                                       input logic en, input logic mbx,
                                       input logic want_write);
        return !cs_n && en && mbx && (wr_sel == want_write);
    endfunction

endpackage

// File: rtl/mbx_sync.sv
module mbx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    generate
        if (STAGES == 1) begin : g_one
            always_comb chain_d = async_in;
        end else begin : g_many
            always_comb chain_d = {chain_q[STAGES-2:0], async_in};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/mbx_channel.sv
module mbx_channel
    import mbx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       snd_clk,
    input  logic       rcv_clk,
    input  logic       rst_n,
    input  logic [1:0] snd_size,
    input  logic [1:0] rcv_size,
    input  logic       snd_wr_acc,
    input  word_t      snd_wdata,
    input  logic       rcv_rd_acc,
    output logic       snd_full,
    output logic       rcv_full,
    output word_t      rcv_rdata
);
    typedef struct packed {
        word_t mail;
        logic  req;
    } snd_state_t;

    typedef struct packed {
        word_t rdata;
        logic  ack;
    } rcv_state_t;

    snd_state_t snd_d, snd_q;
    rcv_state_t rcv_d, rcv_q;
    logic       req_sync, ack_sync;
    word_t      mail_w;

    mbx_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk(rcv_clk), .rst_n(rst_n), .async_in(snd_q.req), .sync_out(req_sync));
    mbx_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk(snd_clk), .rst_n(rst_n), .async_in(rcv_q.ack), .sync_out(ack_sync));

    assign snd_full  = snd_q.req ^ ack_sync;
    assign rcv_full  = req_sync ^ rcv_q.ack;
    assign mail_w    = snd_q.mail;
    assign rcv_rdata = rcv_q.rdata;

    always_comb begin
        snd_d = snd_q;
        if (snd_wr_acc && !snd_full) begin
            snd_d.mail = snd_wdata & lane_mask(snd_size);
            snd_d.req  = ~snd_q.req;
        end
    end

    always_ff @(posedge snd_clk or negedge rst_n) begin
        if (!rst_n) snd_q <= '0;
        else        snd_q <= snd_d;
    end

    always_comb begin
        rcv_d = rcv_q;
        if (rcv_rd_acc) begin
            rcv_d.rdata = snd_q.mail & lane_mask(rcv_size);
            if (rcv_full) rcv_d.ack = ~rcv_q.ack;
        end
    end

    always_ff @(posedge rcv_clk or negedge rst_n) begin
        if (!rst_n) rcv_q <= '0;
        else        rcv_q <= rcv_d;
    end

    // R2
    wr_sets_full_chk: assert property (@(posedge snd_clk) disable iff (!rst_n)
        (snd_wr_acc && !snd_full) |=> snd_full);

    // R6
    wr_blocked_chk: assert property (@(posedge snd_clk) disable iff (!rst_n)
        (snd_wr_acc && snd_full) |=> $stable(mail_w));

    // R5
    rd_clears_chk: assert property (@(posedge rcv_clk) disable iff (!rst_n)
        (rcv_rd_acc && rcv_full) |=> !rcv_full);

    // R9
    rdata_hold_chk: assert property (@(posedge rcv_clk) disable iff (!rst_n)
        !rcv_rd_acc |=> $stable(rcv_rdata));

    // R4
    mail_steady_chk: assert property (@(posedge rcv_clk) disable iff (!rst_n)
        rcv_full |-> $stable(mail_w));
endmodule

// File: rtl/mailbox_pair.sv
module mailbox_pair
    import mbx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_a,
    input  logic              clk_b,
    input  logic              rst_n,
    input  logic [1:0]        b_bus_size,
    input  logic              a_cs_n,
    input  logic              a_wr,
    input  logic              a_en,
    input  logic              a_mbx,
    input  logic [MBX_W-1:0]  a_wdata,
    output logic [MBX_W-1:0]  a_mail_rdata,
    output logic              a_out_full,
    output logic              a_in_full,
    input  logic              b_cs_n,
    input  logic              b_wr,
    input  logic              b_en,
    input  logic              b_mbx,
    input  logic [MBX_W-1:0]  b_wdata,
    output logic [MBX_W-1:0]  b_mail_rdata,
    output logic              b_out_full,
    output logic              b_in_full
);
    localparam logic [1:0] A_SIZE = SZ_FULL;

    logic a_wr_acc, a_rd_acc, b_wr_acc, b_rd_acc;

    assign a_wr_acc = is_access(a_cs_n, a_wr, a_en, a_mbx, 1'b1);
    assign a_rd_acc = is_access(a_cs_n, a_wr, a_en, a_mbx, 1'b0);
    assign b_wr_acc = is_access(b_cs_n, b_wr, b_en, b_mbx, 1'b1);
    assign b_rd_acc = is_access(b_cs_n, b_wr, b_en, b_mbx, 1'b0);

    mbx_channel #(.SYNC_STAGES(SYNC_STAGES)) u_a2b (
        .snd_clk(clk_a), .rcv_clk(clk_b), .rst_n(rst_n),
        .snd_size(A_SIZE), .rcv_size(b_bus_size),
        .snd_wr_acc(a_wr_acc), .snd_wdata(a_wdata), .rcv_rd_acc(b_rd_acc),
        .snd_full(a_out_full), .rcv_full(b_in_full), .rcv_rdata(b_mail_rdata));

    mbx_channel #(.SYNC_STAGES(SYNC_STAGES)) u_b2a (
        .snd_clk(clk_b), .rcv_clk(clk_a), .rst_n(rst_n),
        .snd_size(b_bus_size), .rcv_size(A_SIZE),
        .snd_wr_acc(b_wr_acc), .snd_wdata(b_wdata), .rcv_rd_acc(a_rd_acc),
        .snd_full(b_out_full), .rcv_full(a_in_full), .rcv_rdata(a_mail_rdata));

    // R1
    reset_quiet_chk: assert property (@(posedge clk_a)
        !rst_n |-> !(a_out_full || a_in_full));
endmodule

// File: tb/tb_mailbox_pair.sv
module tb_mailbox_pair;
    logic        clk_a = 0, clk_b = 0, rst_n = 0;
    logic [1:0]  b_bus_size = 2'b00;
    logic        a_cs_n = 1, a_wr = 0, a_en = 0, a_mbx = 0;
    logic        b_cs_n = 1, b_wr = 0, b_en = 0, b_mbx = 0;
    logic [35:0] a_wdata = '0, b_wdata = '0;
    logic [35:0] a_mail_rdata, b_mail_rdata;
    logic        a_out_full, a_in_full, b_out_full, b_in_full;
    int checks = 0, errors = 0;

    always #10 clk_a = ~clk_a;
    always #7  clk_b = ~clk_b;

    mailbox_pair dut (.*);

    task automatic check(input logic ok, input string req, input logic [35:0] act,
                         input logic [35:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic a_access(input logic wr, input logic [35:0] d, input logic mbx,
                            input logic en, input logic cs_n);
        @(negedge clk_a);
        a_cs_n = cs_n; a_wr = wr; a_en = en; a_mbx = mbx; a_wdata = d;
        @(posedge clk_a); #1;
        a_cs_n = 1; a_en = 0; a_mbx = 0; a_wr = 0;
    endtask

    task automatic b_access(input logic wr, input logic [35:0] d, input logic mbx,
                            input logic en, input logic cs_n);
        @(negedge clk_b);
        b_cs_n = cs_n; b_wr = wr; b_en = en; b_mbx = mbx; b_wdata = d;
        @(posedge clk_b); #1;
        b_cs_n = 1; b_en = 0; b_mbx = 0; b_wr = 0;
    endtask

    task automatic wait_a(input int n);
        for (int i = 0; i < n; i++) begin @(posedge clk_a); #1; end
    endtask

    task automatic wait_b(input int n);
        for (int i = 0; i < n; i++) begin @(posedge clk_b); #1; end
    endtask

    task automatic t_reset;
        check(!a_out_full && !a_in_full && !b_out_full && !b_in_full, "R1 flags",
              {a_out_full, a_in_full, b_out_full, b_in_full}, 0);
        check(a_mail_rdata == 0 && b_mail_rdata == 0, "R1 rdata", a_mail_rdata | b_mail_rdata, 0);
    endtask

    task automatic t_ignored;
        a_access(1, 36'hABCDE1234, 0, 1, 0);
        a_access(1, 36'hABCDE1234, 1, 0, 0);
        a_access(1, 36'hABCDE1234, 1, 1, 1);
        wait_b(3);
        check(!a_out_full, "R7 out flag", a_out_full, 0);
        check(!b_in_full, "R7 in flag", b_in_full, 0);
        b_access(0, 0, 1, 1, 0);
        check(b_mail_rdata == 0, "R7 nothing stored", b_mail_rdata, 0);
    endtask

    task automatic t_a2b_basic;
        logic [35:0] w = 36'h9A5C31E7F;
        a_access(1, w, 1, 1, 0);
        check(a_out_full, "R2 out flag set", a_out_full, 1);
        wait_b(1);
        check(!b_in_full, "R3 in flag after 1 edge", b_in_full, 0);
        wait_b(1);
        check(b_in_full, "R3 in flag after 2 edges", b_in_full, 1);
        b_access(0, 0, 1, 1, 0);
        check(b_mail_rdata == w, "R4 read word", b_mail_rdata, w);
        check(!b_in_full, "R5 in flag cleared", b_in_full, 0);
        wait_a(1);
        check(a_out_full, "R5 out flag after 1 edge", a_out_full, 1);
        wait_a(1);
        check(!a_out_full, "R5 out flag after 2 edges", a_out_full, 0);
        wait_b(4);
        check(b_mail_rdata == w, "R9 rdata held", b_mail_rdata, w);
        b_access(0, 0, 1, 1, 0);
        check(b_mail_rdata == w, "R4 reread", b_mail_rdata, w);
    endtask

    task automatic t_blocked;
        logic [35:0] y = 36'h123456789, z = 36'hFEDCBA987;
        a_access(1, y, 1, 1, 0);
        a_access(1, z, 1, 1, 0);
        wait_b(3);
        b_access(0, 0, 1, 1, 0);
        check(b_mail_rdata == y, "R6 held word kept", b_mail_rdata, y);
        wait_a(3);
        check(!a_out_full, "R6 flag released", a_out_full, 0);
    endtask

    task automatic t_size(input logic [1:0] sz, input logic [35:0] mask);
        logic [35:0] w = 36'hF0F0F0F0F;
        b_bus_size = sz;
        a_access(1, w, 1, 1, 0);
        wait_b(3);
        b_access(0, 0, 1, 1, 0);
        check(b_mail_rdata == (w & mask), "R8 port B read lanes", b_mail_rdata, w & mask);
        wait_a(3);
    endtask

    task automatic t_b2a;
        logic [35:0] v = 36'hC3A5F0E1D;
        b_bus_size = 2'b01;
        b_access(1, v, 1, 1, 0);
        check(b_out_full, "R2 B out flag set", b_out_full, 1);
        wait_a(1);
        check(!a_in_full, "R3 A in flag after 1 edge", a_in_full, 0);
        wait_a(1);
        check(a_in_full, "R3 A in flag after 2 edges", a_in_full, 1);
        check(!a_out_full && !b_in_full, "R10 other direction idle",
              {a_out_full, b_in_full}, 0);
        a_access(0, 0, 1, 1, 0);
        check(a_mail_rdata == (v & 36'h3FFFF), "R8 port B write lanes", a_mail_rdata,
              v & 36'h3FFFF);
        wait_b(3);
        check(!b_out_full, "R5 B out flag cleared", b_out_full, 0);
        b_bus_size = 2'b00;
    endtask

    initial begin
        #200_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #3;
        wait_a(1);
        t_reset();
        rst_n = 1;
        wait_a(2);
        t_reset();
        t_ignored();
        t_a2b_basic();
        t_blocked();
        t_size(2'b01, 36'h00003FFFF);
        t_size(2'b10, 36'h0000001FF);
        t_size(2'b11, 36'hFFFFFFFFF);
        t_b2a();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule